// File: doc/BRIEF.md
# Byte Logical Shift Unit with Flag Update

This block shifts one byte left or right, filling with zeros, and works out the carry, overflow, sign and zero flags that the shift produces. The shift amount is either the fixed value one or an amount taken from an 8-bit count input. Only the low five bits of that input are used. A caller raises `start_i` for one cycle with the direction, the byte and the amount. One cycle later the block returns the shifted byte, the four flag values, and a write enable for each flag, together with a one-cycle `done_o` pulse.

The write enables tell the surrounding flag register which flags the shift actually changes. A zero amount changes nothing. Overflow is changed only for an amount of exactly one. The other flags are changed for every nonzero amount. Amounts that push every bit out get fixed handling. An amount equal to the byte width leaves the last bit out in carry. Any larger amount clears both the result and carry.

Top module: `byte_shift_unit`

## Requirements
- R1: While reset is held and after it is released with no start, `done_o` and all four write enables are 0 and `result_o` is 0.
- R2: `done_o` is 1 in exactly the cycle after each cycle in which `start_i` is 1, and 0 otherwise. The outputs present the result of that start during the `done_o` cycle. `result_o` holds its value until the next start.
- R3: When `count_sel_i` is 1, only `count_i[4:0]` sets the shift amount. Bits 7 to 5 are ignored, so an input of 33 behaves exactly like 1.
- R4: When `count_sel_i` is 0, the shift amount is 1 whatever value `count_i` has.
- R5: For an effective amount of 0, `result_o` equals the operand and all four write enables are 0.
- R6: With `dir_i` = 0 (left shift) and an amount n from 1 to 7, the result is the operand shifted left by n with zero fill. CF is operand bit 8−n. When n = 1, OF is result bit 7 XOR CF.
- R7: With `dir_i` = 1 (right shift) and an amount n from 1 to 7, the result is the operand shifted right by n with zero fill. CF is operand bit n−1. When n = 1, OF is operand bit 7.
- R8: For an amount of exactly 8, the result is 0. CF is operand bit 0 for a left shift and operand bit 7 for a right shift.
- R9: For an amount from 9 to 31, the result is 0 and CF is 0.
- R10: `of_we_o` is 1 only when the amount is 1. `cf_we_o`, `sf_we_o` and `zf_we_o` are 1 for every nonzero amount. All write enables are 0 outside a `done_o` cycle, and a flag value output reads 0 whenever its write enable is 0.
- R11: For a nonzero amount, SF equals result bit 7 and ZF is 1 exactly when the result is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request strobe, one cycle per operation |
| dir_i | input | 1 | Shift direction: 0 left, 1 right |
| count_sel_i | input | 1 | Amount source: 0 constant one, 1 from `count_i` |
| operand_i | input | 8 | Byte to shift |
| count_i | input | 8 | Shift amount (low five bits used) |
| result_o | output | 8 | Shifted byte |
| done_o | output | 1 | Result valid pulse |
| cf_o | output | 1 | Carry flag value |
| of_o | output | 1 | Overflow flag value |
| sf_o | output | 1 | Sign flag value |
| zf_o | output | 1 | Zero flag value |
| cf_we_o | output | 1 | Carry flag write enable |
| of_we_o | output | 1 | Overflow flag write enable |
| sf_we_o | output | 1 | Sign flag write enable |
| zf_we_o | output | 1 | Zero flag write enable |

## Verification
Every count input from 0 to 40 is run in both directions over a set of operand bytes. The set includes all-ones, single set bits at each end, and alternating patterns. This separates the bit that lands in carry for each amount, and it tells the width-equal case apart from the overflow-past-width case. Count inputs above 31 confirm that the masked amount wraps. Runs with the constant source use counts that would otherwise mean 0 or large shifts, so a design that reads `count_i` there is exposed. Back-to-back starts then check that each result belongs to its own request. Idle cycles check that the result holds.

// File: rtl/shift_pkg.sv
package shift_pkg;

    typedef enum logic {
        DIR_LEFT  = 1'b0,
        DIR_RIGHT = 1'b1
    } shift_dir_e;

    typedef struct packed {
        logic cf;
        logic of;
        logic sf;
        logic zf;
    } flag_set_t;

    function automatic logic [8:0] flip9(input logic [8:0] v);
        logic [8:0] r;
        for (int i = 0; i < 9; i++) begin
            r[i] = v[8 - i];
        end
        return r;
    endfunction

endpackage

// File: rtl/shift_amount_decode.sv
module shift_amount_decode #(
    parameter int CNT_W  = 8,
    parameter int MASK_W = 5,
    parameter int DATA_W = 8
) (
    input  logic              count_sel_i,
    input  logic [CNT_W-1:0]  count_i,
    output logic [MASK_W-1:0] amount_o,
    output logic              is_zero_o,
    output logic              is_one_o,
    output logic              is_full_o,
    output logic              is_over_o,
    output logic              hi_bits_o
);
    localparam logic [MASK_W-1:0] ONE_AMT  = MASK_W'(1);
    localparam logic [MASK_W-1:0] FULL_AMT = MASK_W'(DATA_W);

    always_comb begin
        amount_o  = count_sel_i ? count_i[MASK_W-1:0] : ONE_AMT;
        is_zero_o = (amount_o == '0);
        is_one_o  = (amount_o == ONE_AMT);
        is_full_o = (amount_o == FULL_AMT);
        is_over_o = (amount_o > FULL_AMT);
        hi_bits_o = count_sel_i && (|count_i[CNT_W-1:MASK_W]);
    end

endmodule

// File: rtl/shift_core.sv
module shift_core
    import shift_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int MASK_W = 5
) (
    input  shift_dir_e        dir_i,
    input  logic [DATA_W-1:0] operand_i,
    input  logic [MASK_W-1:0] amount_i,
    input  logic              is_over_i,
    output logic [DATA_W-1:0] result_o,
    output logic              carry_o
);
    localparam int EXT_W  = DATA_W + 1;
    localparam int STAGES = $clog2(EXT_W);

    logic [EXT_W-1:0] stg [0:STAGES];
    logic [EXT_W-1:0] shifted;

    // Right shifts run through the same left shifter on a bit-reversed word
    always_comb begin
        if (dir_i == DIR_LEFT) begin
            stg[0] = {1'b0, operand_i};
        end else begin
            stg[0] = flip9({operand_i, 1'b0});
        end
    end

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_comb begin
            stg[g+1] = amount_i[g] ? (stg[g] << (1 << g)) : stg[g];
        end
    end

    always_comb begin
        shifted = stg[STAGES];
        if (is_over_i) begin
            result_o = '0;
            carry_o  = 1'b0;
        end else if (dir_i == DIR_LEFT) begin
            result_o = shifted[DATA_W-1:0];
            carry_o  = shifted[DATA_W];
        end else begin
            result_o = flip9(shifted) >> 1;
            carry_o  = shifted[DATA_W];
        end
    end

endmodule

// File: rtl/shift_flag_gen.sv
module shift_flag_gen
    import shift_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  shift_dir_e        dir_i,
    input  logic              operand_msb_i,
    input  logic [DATA_W-1:0] result_i,
    input  logic              carry_i,
    input  logic              is_zero_i,
    input  logic              is_one_i,
    output flag_set_t         value_o,
    output flag_set_t         wen_o
);
    always_comb begin
        wen_o.cf = !is_zero_i;
        wen_o.sf = !is_zero_i;
        wen_o.zf = !is_zero_i;
        wen_o.of = is_one_i;

        value_o.cf = wen_o.cf && carry_i;
        value_o.sf = wen_o.sf && result_i[DATA_W-1];
        value_o.zf = wen_o.zf && (result_i == '0);
        if (dir_i == DIR_LEFT) begin
            value_o.of = wen_o.of && (result_i[DATA_W-1] ^ carry_i);
        end else begin
            value_o.of = wen_o.of && operand_msb_i;
        end
    end

endmodule

// File: rtl/byte_shift_unit.sv
module byte_shift_unit
    import shift_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 8,
    parameter int MASK_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              dir_i,
    input  logic              count_sel_i,
    input  logic [DATA_W-1:0] operand_i,
    input  logic [CNT_W-1:0]  count_i,
    output logic [DATA_W-1:0] result_o,
    output logic              done_o,
    output logic              cf_o,
    output logic              of_o,
    output logic              sf_o,
    output logic              zf_o,
    output logic              cf_we_o,
    output logic              of_we_o,
    output logic              sf_we_o,
    output logic              zf_we_o
);
    typedef struct packed {
        logic [DATA_W-1:0] result;
        flag_set_t         value;
        flag_set_t         wen;
        logic              done;
    } unit_state_t;

    shift_dir_e        dir;
    logic [MASK_W-1:0] amount;
    logic              is_zero, is_one, is_full, is_over, hi_bits;
    logic [DATA_W-1:0] core_result;
    logic              core_carry;
    flag_set_t         flag_value, flag_wen;
    unit_state_t       state_d, state_q;

    assign dir = shift_dir_e'(dir_i);

    shift_amount_decode #(
        .CNT_W (CNT_W),
        .MASK_W(MASK_W),
        .DATA_W(DATA_W)
    ) u_decode (
        .count_sel_i(count_sel_i),
        .count_i    (count_i),
        .amount_o   (amount),
        .is_zero_o  (is_zero),
        .is_one_o   (is_one),
        .is_full_o  (is_full),
        .is_over_o  (is_over),
        .hi_bits_o  (hi_bits)
    );

    shift_core #(
        .DATA_W(DATA_W),
        .MASK_W(MASK_W)
    ) u_core (
        .dir_i    (dir),
        .operand_i(operand_i),
        .amount_i (amount),
        .is_over_i(is_over),
        .result_o (core_result),
        .carry_o  (core_carry)
    );

    shift_flag_gen #(
        .DATA_W(DATA_W)
    ) u_flags (
        .dir_i        (dir),
        .operand_msb_i(operand_i[DATA_W-1]),
        .result_i     (core_result),
        .carry_i      (core_carry),
        .is_zero_i    (is_zero),
        .is_one_i     (is_one),
        .value_o      (flag_value),
        .wen_o        (flag_wen)
    );

    always_comb begin
        state_d       = state_q;
        state_d.done  = start_i;
        state_d.wen   = '0;
        state_d.value = '0;
        if (start_i) begin
            state_d.result = core_result;
            state_d.wen    = flag_wen;
            state_d.value  = flag_value;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign result_o = state_q.result;
    assign done_o   = state_q.done;
    assign cf_o     = state_q.value.cf;
    assign of_o     = state_q.value.of;
    assign sf_o     = state_q.value.sf;
    assign zf_o     = state_q.value.zf;
    assign cf_we_o  = state_q.wen.cf;
    assign of_we_o  = state_q.wen.of;
    assign sf_we_o  = state_q.wen.sf;
    assign zf_we_o  = state_q.wen.zf;

    AST_DONE_FOLLOWS_START: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> done_o); // R2
    AST_DONE_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(start_i)); // R2
    AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> $stable(result_o)); // R2
    AST_WE_ONLY_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (cf_we_o || of_we_o || sf_we_o || zf_we_o) |-> done_o); // R10
    AST_OF_WE_COUNT_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        of_we_o |-> $past(!count_sel_i || (count_i[MASK_W-1:0] == MASK_W'(1)))); // R10
    AST_HIGH_COUNT_BITS_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && $past(hi_bits && count_i[MASK_W-1:0] == '0)) |-> !cf_we_o); // R3
    AST_ZERO_AMOUNT_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !cf_we_o) |-> (result_o == $past(operand_i))); // R5
    AST_FULL_AMOUNT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && (is_full || is_over)) |=> (result_o == '0 && zf_o)); // R8
    AST_OVER_NO_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && is_over) |=> !cf_o); // R9
    AST_ZF_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        zf_we_o |-> (zf_o == (result_o == '0))); // R11
    AST_SF_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        sf_we_o |-> (sf_o == result_o[DATA_W-1])); // R11

endmodule

// File: tb/sim_byte_shift_unit.sv
module sim_byte_shift_unit;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       dir_i = 1'b0;
    logic       count_sel_i = 1'b0;
    logic [7:0] operand_i = 8'h00;
    logic [7:0] count_i = 8'h00;
    logic [7:0] result_o;
    logic       done_o, cf_o, of_o, sf_o, zf_o;
    logic       cf_we_o, of_we_o, sf_we_o, zf_we_o;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit checking = 1'b0;

    // Expected outputs, produced behaviourally
    logic [7:0] exp_result = 8'h00;
    logic       exp_done = 1'b0;
    logic [7:0] exp_flags = 8'h00; // {cf,of,sf,zf, cf_we,of_we,sf_we,zf_we}
    string      exp_tag = "R1";

    always #4 clk = ~clk;

    byte_shift_unit u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .dir_i(dir_i),
        .count_sel_i(count_sel_i), .operand_i(operand_i), .count_i(count_i),
        .result_o(result_o), .done_o(done_o),
        .cf_o(cf_o), .of_o(of_o), .sf_o(sf_o), .zf_o(zf_o),
        .cf_we_o(cf_we_o), .of_we_o(of_we_o), .sf_we_o(sf_we_o), .zf_we_o(zf_we_o)
    );

    // One bit per step, exactly as a serial shifter would move it
    function automatic logic [15:0] model(input logic d, input logic sel,
                                          input logic [7:0] v, input logic [7:0] c);
        int n;
        logic [7:0] r;
        logic cy, ov;
        n  = sel ? int'(c % 32) : 1;
        r  = v;
        cy = 1'b0;
        if (n == 0) return {v, 8'h00};
        for (int i = 0; i < n; i++) begin
            if (!d) begin cy = r[7]; r = r << 1; end
            else    begin cy = r[0]; r = r >> 1; end
        end
        ov = (n == 1) ? (!d ? (r[7] ^ cy) : v[7]) : 1'b0;
        return {r, cy, ov, r[7], (r == 8'h00), 1'b1, (n == 1), 1'b1, 1'b1};
    endfunction

    function automatic string tag_for(input logic d, input logic sel, input logic [7:0] c);
        int n;
        n = sel ? int'(c % 32) : 1;
        if (!sel && c != 8'd1) return "R4";
        if (sel && c > 8'd31)  return "R3";
        if (n == 0)            return "R5";
        if (n == 8)            return "R8";
        if (n > 8)             return "R9";
        return d ? "R7" : "R6";
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            exp_result <= 8'h00;
            exp_done   <= 1'b0;
            exp_flags  <= 8'h00;
            exp_tag    <= "R1";
        end else begin
            logic [15:0] m;
            m = model(dir_i, count_sel_i, operand_i, count_i);
            exp_done <= start_i;
            if (start_i) begin
                exp_result <= m[15:8];
                exp_flags  <= m[7:0];
                exp_tag    <= tag_for(dir_i, count_sel_i, count_i);
            end else begin
                exp_flags  <= 8'h00;
                exp_tag    <= "R2";
            end
        end
    end

    task automatic check(input string req, input string what, input int act, input int expv);
        checks++;
        if (act != expv) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        if (checking) begin
            check("R2", "done", int'(done_o), int'(exp_done));
            check(exp_tag, "result", int'(result_o), int'(exp_result));
            check("R10", "write enables", int'({cf_we_o, of_we_o, sf_we_o, zf_we_o}),
                  int'(exp_flags[3:0]));
            check(exp_flags[0] ? "R11" : exp_tag, "flag values",
                  int'({cf_o, of_o, sf_o, zf_o}), int'(exp_flags[7:4]));
        end
    end

    task automatic issue(input logic d, input logic sel, input logic [7:0] v,
                         input logic [7:0] c, input bit gap);
        @(negedge clk);
        start_i = 1'b1; dir_i = d; count_sel_i = sel; operand_i = v; count_i = c;
        if (gap) begin
            @(negedge clk);
            start_i = 1'b0;
            operand_i = ~v; count_i = 8'hA5; dir_i = ~d;
        end
    endtask

    initial begin
        logic [7:0] pats [10] = '{8'hFF, 8'h80, 8'h01, 8'hAA, 8'h55, 8'h00,
                                 8'h81, 8'h40, 8'hC3, 8'h7E};
        repeat (2) @(negedge clk);
        // R1: reset state
        check("R1", "reset done", int'(done_o), 0);
        check("R1", "reset result", int'(result_o), 0);
        check("R1", "reset enables", int'({cf_we_o, of_we_o, sf_we_o, zf_we_o}), 0);
        rst_n = 1'b1;
        checking = 1'b1;
        repeat (3) @(negedge clk);
        // R6 R7 R8 R9 R5: every amount, both directions
        for (int d = 0; d < 2; d++)
            for (int p = 0; p < 10; p++)
                for (int c = 0; c <= 40; c++)
                    issue(d[0], 1'b1, pats[p], 8'(c), 1'b1);
        // R3: upper count bits ignored
        for (int p = 0; p < 10; p++) begin
            issue(1'b0, 1'b1, pats[p], 8'd225, 1'b1);
            issue(1'b1, 1'b1, pats[p], 8'd168, 1'b1);
            issue(1'b0, 1'b1, pats[p], 8'd64, 1'b1);
        end
        // R4: constant-one source ignores count_i
        for (int p = 0; p < 10; p++) begin
            issue(1'b0, 1'b0, pats[p], 8'd0, 1'b1);
            issue(1'b1, 1'b0, pats[p], 8'd8, 1'b1);
            issue(1'b1, 1'b0, pats[p], 8'd1, 1'b1);
        end
        // R2: back-to-back starts
        for (int c = 0; c < 12; c++)
            issue(c[0], 1'b1, pats[c % 10], 8'(c), 1'b0);
        @(negedge clk);
        start_i = 1'b0;
        repeat (4) @(negedge clk);
        checking = 1'b0;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        wait (cycles > 150000);
        checks++;
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule